// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Threshold Flags

This block is a first-in first-out buffer of 18-bit words whose write and read ports run on independent clocks. Each port has an active-low enable. The buffer drives five active-low status outputs. Empty and almost-empty belong to the read clock. Full, almost-full and half-full belong to the write clock. Each flag is a register in the domain that owns it. The two pointers cross between the domains as Gray code through a chain of synchronizer flops.

The almost-empty and almost-full thresholds come in as offset inputs from a separate offset-register block. A one-cycle high pulse on the rewind input, sampled by the read clock, moves the read pointer back to physical location zero. The words stored since reset can then be read a second time. The read data output is registered and keeps the last word read when the buffer runs dry. Depth is a power-of-two parameter.

Top module: `flagged_async_fifo`

## Requirements
- R1: A word is stored on a rising `wr_clk` edge when `wr_en_n` is 0 and `full_n` is 1. A word is read on a rising `rd_clk` edge when `rd_en_n` is 0, `empty_n` is 1 and `rewind` is 0. The read word appears on `rd_data` after that edge, and words leave in the order they were stored.
- R2: While `full_n` is 0 the write enable has no effect and no word is stored. While `empty_n` is 0 the read enable has no effect.
- R3: A flag asserts on the edge of its own clock that completes the operation causing it, never later. A flag that clears because of activity on the other port clears within a few cycles of its own clock.
- R4: `almost_empty_n` is 0 while the stored count is less than or equal to `ae_offset`, an unsigned word count.
- R5: `almost_full_n` is 0 while the stored count is greater than or equal to DEPTH minus `af_offset`, an unsigned word count no larger than DEPTH.
- R6: `half_full_n` is 0 while the stored count is DEPTH/2+1 or more, and 1 at DEPTH/2 or fewer.
- R7: While `rst_n` is 0 and after it is released, the buffer is empty: `empty_n`=0, `almost_empty_n`=0, `half_full_n`=1, `almost_full_n`=1, `full_n`=1 and `rd_data`=0.
- R8: When the buffer is empty, `rd_data` keeps the last word read, even when further reads are attempted.
- R9: A high `rewind` on a `rd_clk` edge sets the read pointer to location zero. Later reads return the stored words again from the first one until the read pointer meets the write pointer, and every flag follows the new pointer distance.
- R10: `full_n` is 0 exactly when DEPTH words are stored. `empty_n` is 0 exactly when no word is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-port clock |
| rd_clk | input | 1 | Read-port clock |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| wr_en_n | input | 1 | Active-low write enable |
| wr_data | input | WORD_W | Word to store |
| rd_en_n | input | 1 | Active-low read enable |
| rewind | input | 1 | Active-high retransmit request, sampled by rd_clk |
| ae_offset | input | $clog2(DEPTH)+1 | Almost-empty threshold in words |
| af_offset | input | $clog2(DEPTH)+1 | Almost-full distance from full in words |
| rd_data | output | WORD_W | Registered read word |
| empty_n | output | 1 | Active-low empty flag (read domain) |
| almost_empty_n | output | 1 | Active-low almost-empty flag (read domain) |
| half_full_n | output | 1 | Active-low half-full flag (write domain) |
| almost_full_n | output | 1 | Active-low almost-full flag (write domain) |
| full_n | output | 1 | Active-low full flag (write domain) |

## Verification
The assertions assume that `rewind` is pulsed only while both enables are idle. They also assume that no more than DEPTH words have been written since reset when it is pulsed, and that the offsets stay constant while traffic flows. The bench follows these rules. It changes offsets only during reset and pulses `rewind` at the falling edge of `rd_clk` with both enables high. It then waits several cycles of each clock before starting the replay. Enables are driven at falling edges, and each write or read is booked in the reference queue only if the owning flag showed room at that moment.

// File: rtl/dcf_pkg.sv
package dcf_pkg;

   // Binary to reflected Gray code, width-agnostic up to 32 bits.
   function automatic logic [31:0] bin2gray(input logic [31:0] b);
      return b ^ (b >> 1);
   endfunction

   // Reflected Gray code back to binary.
   function automatic logic [31:0] gray2bin(input logic [31:0] g);
      logic [31:0] b;
      b[31] = g[31];
      for (int i = 30; i >= 0; i--) begin
         b[i] = b[i+1] ^ g[i];
      end
      return b;
   endfunction

endpackage

// File: rtl/dcf_sync.sv
module dcf_sync #(
   parameter int W      = 5,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   logic [W-1:0] stg [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < STAGES; s++) stg[s] <= '0;
      end else begin
         stg[0] <= d;
         for (int s = 1; s < STAGES; s++) stg[s] <= stg[s-1];
      end
   end

   assign q = stg[STAGES-1];

endmodule

// File: rtl/dcf_mem.sv
module dcf_mem #(
   parameter int W  = 18,
   parameter int AW = 6
) (
   input  logic          wr_clk,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [W-1:0]  wdata,
   input  logic [AW-1:0] raddr,
   output logic [W-1:0]  rdata
);

   localparam int DEPTH = 1 << AW;

   logic [W-1:0] store [DEPTH];

   always_ff @(posedge wr_clk) begin
      if (we) store[waddr] <= wdata;
   end

   assign rdata = store[raddr];

endmodule

// File: rtl/dcf_wr_side.sv
module dcf_wr_side #(
   parameter int DEPTH = 64,
   parameter int AW    = 6,
   parameter int PW    = AW + 1
) (
   input  logic          wr_clk,
   input  logic          rst_n,
   input  logic          wr_en_n,
   input  logic [PW-1:0] rgray_sync,
   input  logic [PW-1:0] af_off,
   output logic          wr_fire,
   output logic [AW-1:0] waddr,
   output logic [PW-1:0] wgray,
   output logic          full_n,
   output logic          af_n,
   output logic          hf_n
);

   localparam logic [PW-1:0] DEPTH_P = PW'(DEPTH);
   localparam logic [PW-1:0] HALF_P  = PW'(DEPTH / 2);

   logic [PW-1:0] wbin, wbin_nx, rbin_s, cnt_nx;

   assign wr_fire = !wr_en_n && full_n;
   assign wbin_nx = wbin + PW'(wr_fire);
   assign rbin_s  = PW'(dcf_pkg::gray2bin(32'(rgray_sync)));
   assign cnt_nx  = wbin_nx - rbin_s;
   assign waddr   = wbin[AW-1:0];

   always_ff @(posedge wr_clk or negedge rst_n) begin
      if (!rst_n) begin
         wbin   <= '0;
         wgray  <= '0;
         full_n <= 1'b1;
         af_n   <= 1'b1;
         hf_n   <= 1'b1;
      end else begin
         wbin   <= wbin_nx;
         wgray  <= PW'(dcf_pkg::bin2gray(32'(wbin_nx)));
         full_n <= !(cnt_nx == DEPTH_P);
         af_n   <= !(cnt_nx >= (DEPTH_P - af_off));
         hf_n   <= !(cnt_nx > HALF_P);
      end
   end

   // R2
   no_overflow_chk: assert property (@(posedge wr_clk) disable iff (!rst_n)
      !full_n |=> $stable(wbin));

   // R6
   full_implies_hf_chk: assert property (@(posedge wr_clk) disable iff (!rst_n)
      !full_n |-> (!hf_n && !af_n));

endmodule

// File: rtl/dcf_rd_side.sv
module dcf_rd_side #(
   parameter int W  = 18,
   parameter int AW = 6,
   parameter int PW = AW + 1
) (
   input  logic          rd_clk,
   input  logic          rst_n,
   input  logic          rd_en_n,
   input  logic          rewind,
   input  logic [PW-1:0] wgray_sync,
   input  logic [PW-1:0] ae_off,
   input  logic [W-1:0]  mem_word,
   output logic [AW-1:0] raddr,
   output logic [PW-1:0] rgray,
   output logic [W-1:0]  rd_data,
   output logic          empty_n,
   output logic          ae_n
);

   logic [PW-1:0] rbin, rbin_nx, wbin_s, cnt_nx;
   logic          rd_fire;

   assign rd_fire = !rd_en_n && empty_n && !rewind;
   assign rbin_nx = rewind ? '0 : rbin + PW'(rd_fire);
   assign wbin_s  = PW'(dcf_pkg::gray2bin(32'(wgray_sync)));
   assign cnt_nx  = wbin_s - rbin_nx;
   assign raddr   = rbin[AW-1:0];

   always_ff @(posedge rd_clk or negedge rst_n) begin
      if (!rst_n) begin
         rbin    <= '0;
         rgray   <= '0;
         rd_data <= '0;
         empty_n <= 1'b0;
         ae_n    <= 1'b0;
      end else begin
         rbin    <= rbin_nx;
         rgray   <= PW'(dcf_pkg::bin2gray(32'(rbin_nx)));
         empty_n <= (cnt_nx != '0);
         ae_n    <= !(cnt_nx <= ae_off);
         if (rd_fire) rd_data <= mem_word;
      end
   end

   // R2
   no_underflow_chk: assert property (@(posedge rd_clk) disable iff (!rst_n)
      (!empty_n && !rewind) |=> $stable(rbin));

   // R8
   hold_last_chk: assert property (@(posedge rd_clk) disable iff (!rst_n)
      !empty_n |=> $stable(rd_data));

   // R4
   empty_implies_ae_chk: assert property (@(posedge rd_clk) disable iff (!rst_n)
      !empty_n |-> !ae_n);

   // R9
   rewind_zero_chk: assert property (@(posedge rd_clk) disable iff (!rst_n)
      rewind |=> (rbin == '0));

endmodule

// File: rtl/flagged_async_fifo.sv
module flagged_async_fifo #(
   parameter int WORD_W      = 18,
   parameter int DEPTH       = 64,
   parameter int SYNC_STAGES = 2,
   localparam int AW         = $clog2(DEPTH),
   localparam int PW         = AW + 1
) (
   input  logic              wr_clk,
   input  logic              rd_clk,
   input  logic              rst_n,
   input  logic              wr_en_n,
   input  logic [WORD_W-1:0] wr_data,
   input  logic              rd_en_n,
   input  logic              rewind,
   input  logic [PW-1:0]     ae_offset,
   input  logic [PW-1:0]     af_offset,
   output logic [WORD_W-1:0] rd_data,
   output logic              empty_n,
   output logic              almost_empty_n,
   output logic              half_full_n,
   output logic              almost_full_n,
   output logic              full_n
);

   if ((1 << AW) != DEPTH || DEPTH < 4) begin : g_bad_depth
      $error("DEPTH must be a power of two of at least 4");
   end
   if (PW > 32) begin : g_bad_width
      $error("pointer width exceeds 32 bits");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end

   logic              wr_fire;
   logic [AW-1:0]     waddr, raddr;
   logic [PW-1:0]     wgray, rgray, wgray_rs, rgray_ws;
   logic [WORD_W-1:0] mem_word;

   dcf_mem #(.W(WORD_W), .AW(AW)) i_mem (
      .wr_clk (wr_clk),
      .we     (wr_fire),
      .waddr  (waddr),
      .wdata  (wr_data),
      .raddr  (raddr),
      .rdata  (mem_word)
   );

   dcf_sync #(.W(PW), .STAGES(SYNC_STAGES)) i_w2r (
      .clk   (rd_clk),
      .rst_n (rst_n),
      .d     (wgray),
      .q     (wgray_rs)
   );

   dcf_sync #(.W(PW), .STAGES(SYNC_STAGES)) i_r2w (
      .clk   (wr_clk),
      .rst_n (rst_n),
      .d     (rgray),
      .q     (rgray_ws)
   );

   dcf_wr_side #(.DEPTH(DEPTH), .AW(AW), .PW(PW)) i_wr (
      .wr_clk     (wr_clk),
      .rst_n      (rst_n),
      .wr_en_n    (wr_en_n),
      .rgray_sync (rgray_ws),
      .af_off     (af_offset),
      .wr_fire    (wr_fire),
      .waddr      (waddr),
      .wgray      (wgray),
      .full_n     (full_n),
      .af_n       (almost_full_n),
      .hf_n       (half_full_n)
   );

   dcf_rd_side #(.W(WORD_W), .AW(AW), .PW(PW)) i_rd (
      .rd_clk     (rd_clk),
      .rst_n      (rst_n),
      .rd_en_n    (rd_en_n),
      .rewind     (rewind),
      .wgray_sync (wgray_rs),
      .ae_off     (ae_offset),
      .mem_word   (mem_word),
      .raddr      (raddr),
      .rgray      (rgray),
      .rd_data    (rd_data),
      .empty_n    (empty_n),
      .ae_n       (almost_empty_n)
   );

endmodule

// File: tb/test_flagged_async_fifo.sv
module test_flagged_async_fifo;

   localparam int D  = 16;
   localparam int PW = $clog2(D) + 1;

   logic          wr_clk = 1'b0, rd_clk = 1'b0, rst_n = 1'b0;
   logic          wr_en_n = 1'b1, rd_en_n = 1'b1, rewind = 1'b0;
   logic [17:0]   wr_data = '0;
   logic [PW-1:0] ae_offset = '0, af_offset = '0;
   logic [17:0]   rd_data;
   logic          empty_n, almost_empty_n, half_full_n, almost_full_n, full_n;

   int checks = 0, errors = 0;
   logic [17:0] q[$];
   logic [17:0] next_word = 18'h100;

   always #5 wr_clk = ~wr_clk;
   always #7 rd_clk = ~rd_clk;

   flagged_async_fifo #(.WORD_W(18), .DEPTH(D)) i_flagged_async_fifo (
      .wr_clk, .rd_clk, .rst_n, .wr_en_n, .wr_data, .rd_en_n, .rewind,
      .ae_offset, .af_offset, .rd_data, .empty_n, .almost_empty_n,
      .half_full_n, .almost_full_n, .full_n
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic settle();
      repeat (8) @(negedge rd_clk);
      repeat (8) @(negedge wr_clk);
   endtask

   task automatic do_reset(input int n, input int m);
      rst_n = 1'b0;
      ae_offset = PW'(n);
      af_offset = PW'(m);
      repeat (3) @(negedge wr_clk);
      q.delete();
      rst_n = 1'b1;
      settle();
   endtask

   task automatic write_one();
      @(negedge wr_clk);
      wr_data = next_word;
      wr_en_n = 1'b0;
      if (full_n) q.push_back(next_word);
      next_word++;
      @(negedge wr_clk);
      wr_en_n = 1'b1;
   endtask

   task automatic read_one(input string tag);
      logic [17:0] exp;
      logic        fire;
      @(negedge rd_clk);
      fire = empty_n;
      exp  = fire ? q.pop_front() : rd_data;
      rd_en_n = 1'b0;
      @(negedge rd_clk);
      rd_en_n = 1'b1;
      chk(tag, 32'(rd_data), 32'(exp));
   endtask

   task automatic flags_at(input int k, input int n, input int m);
      chk("R10 empty", 32'(empty_n), 32'(k != 0));
      chk("R4 almost-empty", 32'(almost_empty_n), 32'(!(k <= n)));
      chk("R6 half-full", 32'(half_full_n), 32'(!(k >= D/2 + 1)));
      chk("R5 almost-full", 32'(almost_full_n), 32'(!(k >= D - m)));
      chk("R10 full", 32'(full_n), 32'(k != D));
   endtask

   task automatic t_reset();
      rst_n = 1'b0;
      #40;
      chk("R7 empty in reset", 32'(empty_n), 32'd0);
      chk("R7 ae in reset", 32'(almost_empty_n), 32'd0);
      chk("R7 hf in reset", 32'(half_full_n), 32'd1);
      chk("R7 af in reset", 32'(almost_full_n), 32'd1);
      chk("R7 full in reset", 32'(full_n), 32'd1);
      chk("R7 data in reset", 32'(rd_data), 32'd0);
      do_reset(3, 2);
      flags_at(0, 3, 2);
   endtask

   task automatic t_thresholds(input int n, input int m);
      do_reset(n, m);
      for (int k = 1; k <= D; k++) begin
         write_one();
         // write-domain flags must be up on the edge of the write itself
         if (k == D) chk("R3 full immediate", 32'(full_n), 32'd0);
         if (k == D - m) chk("R3 af immediate", 32'(almost_full_n), 32'd0);
         if (k == D/2 + 1) chk("R3 hf immediate", 32'(half_full_n), 32'd0);
         settle();
         flags_at(k, n, m);
      end
      // writes while full must be dropped
      @(negedge wr_clk);
      wr_data = 18'h3FFFF;
      wr_en_n = 1'b0;
      repeat (3) @(negedge wr_clk);
      wr_en_n = 1'b1;
      settle();
      chk("R2 still full", 32'(full_n), 32'd0);
      for (int k = D - 1; k >= 0; k--) begin
         read_one("R1 drain order");
         if (k == n) chk("R3 ae immediate", 32'(almost_empty_n), 32'd0);
         if (k == 0) chk("R3 empty immediate", 32'(empty_n), 32'd0);
      end
      settle();
      flags_at(0, n, m);
      // reads while empty hold the last word
      begin
         logic [17:0] last;
         last = rd_data;
         @(negedge rd_clk);
         rd_en_n = 1'b0;
         repeat (3) @(negedge rd_clk);
         rd_en_n = 1'b1;
         chk("R8 hold last word", 32'(rd_data), 32'(last));
         chk("R2 still empty", 32'(empty_n), 32'd0);
      end
   endtask

   task automatic t_retransmit();
      logic [17:0] saved[$];
      do_reset(2, 2);
      for (int k = 0; k < 6; k++) write_one();
      saved = q;
      settle();
      for (int k = 0; k < 3; k++) read_one("R1 pre-rewind read");
      settle();
      chk("R4 ae at 3 words", 32'(almost_empty_n), 32'd1);
      @(negedge rd_clk);
      rewind = 1'b1;
      @(negedge rd_clk);
      rewind = 1'b0;
      settle();
      q = saved;
      chk("R9 not empty after rewind", 32'(empty_n), 32'd1);
      chk("R9 ae after rewind", 32'(almost_empty_n), 32'd1);
      chk("R9 hf after rewind", 32'(half_full_n), 32'd1);
      for (int k = 0; k < 6; k++) read_one("R9 replay data");
      chk("R9 empty after replay", 32'(empty_n), 32'd0);
   endtask

   task automatic t_stream();
      bit wdone = 1'b0;
      do_reset(4, 4);
      fork
         begin
            for (int c = 0; c < 400; c++) begin
               @(negedge wr_clk);
               wr_en_n = ($urandom_range(0, 9) < 6) ? 1'b0 : 1'b1;
               wr_data = next_word;
               if (!wr_en_n && full_n) begin
                  q.push_back(next_word);
                  next_word++;
               end
            end
            @(negedge wr_clk);
            wr_en_n = 1'b1;
            wdone = 1'b1;
         end
         begin
            logic [17:0] exp = '0;
            bit pend = 1'b0;
            int idle = 0;
            while (idle < 20) begin
               @(negedge rd_clk);
               if (pend) chk("R1 stream order", 32'(rd_data), 32'(exp));
               pend = 1'b0;
               rd_en_n = ($urandom_range(0, 9) < 5) ? 1'b0 : 1'b1;
               if (!rd_en_n && empty_n) begin
                  exp  = q.pop_front();
                  pend = 1'b1;
               end
               idle = (wdone && q.size() == 0) ? idle + 1 : 0;
            end
            rd_en_n = 1'b1;
         end
      join
      settle();
      chk("R10 empty after stream", 32'(empty_n), 32'd0);
   endtask

   initial begin
      #2_000_000;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      t_reset();
      t_thresholds(3, 2);
      t_thresholds(5, 4);
      t_thresholds(0, 0);
      t_retransmit();
      t_stream();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule